// File: doc/BRIEF.md
# Bit Reorder and Saturation Unit

This block is a 32-bit datapath that applies one of eight operations to an operand, chosen by a 3-bit opcode. It covers byte and bit permutations, rotation, leading-zero counting, and signed or unsigned clamping to a programmable width. A 6-bit side field gives either the rotate amount or the saturation width.

The logic is combinational. An output register is enabled by default, which gives a latency of one clock. Besides the result, the block raises a flag when a saturating operation had to clamp its input. Software-facing state, carry handling and pipeline control are left to the host datapath.

Top module: `bitsat_unit`

## Requirements
- R1: Opcode 0 reverses the four bytes of the operand: byte 0 goes to byte 3, byte 1 to byte 2, and so on (0x47110815 gives 0x15081147).
- R2: Opcode 1 exchanges the two bytes inside each 16-bit half on its own (0x47110815 gives 0x11471508).
- R3: Opcode 2 exchanges bits [7:0] and [15:8]. The 16-bit value that results is sign-extended from its bit 15, and operand bits [31:16] are ignored (0x0080 gives 0xFFFF8000).
- R4: Opcode 3 mirrors all 32 bits, so bit i moves to bit 31-i.
- R5: Opcode 4 rotates the operand right by the amount field modulo 32. An amount of 0 or 32 returns the operand unchanged.
- R6: Opcode 5 returns the number of leading zero bits of the operand. The count is 32 for zero and 0 when bit 31 is set.
- R7: Opcode 6 treats the operand as signed and clamps it to the range -2^(N-1) .. 2^(N-1)-1. N is the width field, held to the range 1..32, so 0 acts as 1 and values above 32 act as 32.
- R8: Opcode 7 treats the operand as signed and clamps it to the range 0 .. 2^N-1. N is the width field, with values above 31 acting as 31. Any negative operand gives 0, and N=0 always gives 0.
- R9: The saturation flag is 1 only when opcode 6 or 7 changed the operand's value. For an in-range operand it is 0, and for opcodes 0..5 it is always 0.
- R10: With the output register enabled (the default), the result and flag appear on the first rising clock edge after the inputs. The active-low asynchronous reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation select |
| opa_i | input | 32 | Operand |
| amt_i | input | 6 | Rotate amount or saturation width |
| res_o | output | 32 | Result |
| sat_o | output | 1 | Saturation occurred |

## Verification
The bench targets the edges of each operation:
- **Rotate by 32, 33 and 63.** A rotator that does not reduce the amount modulo 32 returns zero or shifted garbage.
- **Count of an all-zero operand.** A priority encoder that drops the empty case returns 31 or 0 instead of 32.
- **Saturation widths 0, 1 and 40.** A design that does not clamp the width builds a bad limit and produces wrong values or flags.
- **Flag at the exact range boundaries.** Values such as 127 and 128 at width 8 and the most negative 32-bit value separate a clamp that is off by one.
- **Upper bits under the signed halfword swap.** Placing garbage in bits [31:16] shows up as a wrong sign extension.
- **Negative operands under unsigned saturation.** A magnitude compare that ignores the sign lets these through unchanged.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [2:0] {
    OP_BREV  = 3'd0,
    OP_HSWAP = 3'd1,
    OP_SHSWP = 3'd2,
    OP_BITRV = 3'd3,
    OP_ROTR  = 3'd4,
    OP_CLZ   = 3'd5,
    OP_SSAT  = 3'd6,
    OP_USAT  = 3'd7
  } bsu_op_e;
endpackage

// File: rtl/bitsat_permute.sv
module bitsat_permute
  import bsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int NH    = DATA_W / 16,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  bsu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0]   brev, hswap, shswp, bitrv, rotr;
  logic [2*DATA_W-1:0] dbl;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign brev[8*b +: 8] = a_i[8*(NB-1-b) +: 8];
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign hswap[16*h +: 8]     = a_i[16*h+8 +: 8];
    assign hswap[16*h+8 +: 8]   = a_i[16*h +: 8];
  end

  assign shswp = {{(DATA_W-16){a_i[7]}}, a_i[7:0], a_i[15:8]};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign bitrv[i] = a_i[DATA_W-1-i];
  end

  assign dbl  = {a_i, a_i} >> rot_i;
  assign rotr = dbl[DATA_W-1:0];

  always_comb begin
    unique case (op_i)
      OP_BREV:  y_o = brev;
      OP_HSWAP: y_o = hswap;
      OP_SHSWP: y_o = shswp;
      OP_BITRV: y_o = bitrv;
      default:  y_o = rotr;
    endcase
  end
endmodule

// File: rtl/bitsat_clz.sv
module bitsat_clz #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] a_i,
  output logic [CNT_W-1:0]  cnt_o
);
  // highest set bit wins: later iterations overwrite
  always_comb begin
    cnt_o = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (a_i[i]) cnt_o = CNT_W'(DATA_W - 1 - i);
    end
  end
endmodule

// File: rtl/bitsat_saturate.sv
module bitsat_saturate #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W) + 1
) (
  input  logic              is_signed_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [AMT_W-1:0]  width_i,
  output logic [DATA_W-1:0] y_o,
  output logic              sat_o
);
  localparam logic [AMT_W-1:0] SMAX = AMT_W'(DATA_W);
  localparam logic [AMT_W-1:0] UMAX = AMT_W'(DATA_W - 1);

  logic [AMT_W-1:0]         n_s, n_u;
  logic signed [DATA_W:0]   a_x, lim_s, hi_s, lo_s, hi_u;

  // legalize width per mode
  always_comb begin
    n_s = width_i;
    if (width_i == '0)  n_s = AMT_W'(1);
    if (width_i > SMAX) n_s = SMAX;
    n_u = (width_i > UMAX) ? UMAX : width_i;
  end

  assign a_x   = {a_i[DATA_W-1], a_i};
  assign lim_s = $signed((DATA_W+1)'(1) << (n_s - AMT_W'(1)));
  assign hi_s  = lim_s - 1;
  assign lo_s  = -lim_s;
  assign hi_u  = $signed(((DATA_W+1)'(1) << n_u) - (DATA_W+1)'(1));

  always_comb begin
    y_o   = a_i;
    sat_o = 1'b0;
    if (is_signed_i) begin
      if (a_x > hi_s) begin
        y_o = hi_s[DATA_W-1:0]; sat_o = 1'b1;
      end else if (a_x < lo_s) begin
        y_o = lo_s[DATA_W-1:0]; sat_o = 1'b1;
      end
    end else begin
      if (a_x < 0) begin
        y_o = '0; sat_o = 1'b1;
      end else if (a_x > hi_u) begin
        y_o = hi_u[DATA_W-1:0]; sat_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitsat_unit.sv
module bitsat_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int AMT_W  = $clog2(DATA_W) + 1,
  localparam int ROT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] res_o,
  output logic              sat_o
);
  bsu_op_e           op;
  logic [DATA_W-1:0] perm_y, sat_y, res_d, res_q;
  logic [AMT_W-1:0]  clz_cnt;
  logic              sat_hit, sat_d, sat_q;

  assign op = bsu_op_e'(op_i);

  bitsat_permute #(.DATA_W(DATA_W)) u_perm (
    .op_i (op),
    .a_i  (opa_i),
    .rot_i(amt_i[ROT_W-1:0]),
    .y_o  (perm_y)
  );

  bitsat_clz #(.DATA_W(DATA_W)) u_clz (
    .a_i  (opa_i),
    .cnt_o(clz_cnt)
  );

  bitsat_saturate #(.DATA_W(DATA_W)) u_sat (
    .is_signed_i(op == OP_SSAT),
    .a_i        (opa_i),
    .width_i    (amt_i),
    .y_o        (sat_y),
    .sat_o      (sat_hit)
  );

  always_comb begin
    res_d = perm_y;
    sat_d = 1'b0;
    unique case (op)
      OP_CLZ:           res_d = DATA_W'(clz_cnt);
      OP_SSAT, OP_USAT: begin res_d = sat_y; sat_d = sat_hit; end
      default:          ;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q <= '0;
        sat_q <= 1'b0;
      end else begin
        res_q <= res_d;
        sat_q <= sat_d;
      end
    end
  end else begin : g_comb
    always_comb begin
      res_q = res_d;
      sat_q = sat_d;
    end
  end

  assign res_o = res_q;
  assign sat_o = sat_q;
endmodule

// File: rtl/bitsat_unit_chk.sv
module bitsat_unit_chk #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int AMT_W  = $clog2(DATA_W) + 1,
  localparam int ROT_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [AMT_W-1:0]  amt_i,
  input logic [DATA_W-1:0] res_o,
  input logic              sat_o
);
  if (REG_OUT) begin : g_reg_props
    a_r9_flag_only_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i < 3'd6) |=> !sat_o);

    a_r8_usat_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd7) |=> !res_o[DATA_W-1]);

    a_r7_ssat_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd6) |=> (res_o[DATA_W-1] == $past(opa_i[DATA_W-1])));

    a_r6_clz_msb_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd5 && opa_i[DATA_W-1]) |=> (res_o == '0));

    a_r5_rot_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd4 && amt_i[ROT_W-1:0] == '0) |=> (res_o == $past(opa_i)));

    a_r3_sext_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd2) |=> (res_o[DATA_W-1:15] == '0 || res_o[DATA_W-1:15] == '1));
  end

  always_comb begin
    if (!rst_ni && REG_OUT) a_r10_reset_clear: assert (res_o == '0 && !sat_o);
  end
endmodule

bind bitsat_unit bitsat_unit_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/bitsat_unit_test.sv
module bitsat_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] opa_i = '0;
  logic [5:0]  amt_i = '0;
  logic [31:0] res_o;
  logic        sat_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bitsat_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .opa_i(opa_i),
    .amt_i(amt_i), .res_o(res_o), .sat_o(sat_o)
  );

  task automatic check(string req, logic [31:0] exp_r, logic exp_s);
    n_vec++;
    if (res_o !== exp_r || sat_o !== exp_s) begin
      n_bad++;
      $display("FAIL %s: res=%h sat=%b expected res=%h sat=%b", req, res_o, sat_o, exp_r, exp_s);
    end
  endtask

  task automatic run(string req, logic [2:0] op, logic [31:0] a, logic [5:0] amt,
                     logic [31:0] exp_r, logic exp_s);
    @(negedge clk_i);
    op_i = op; opa_i = a; amt_i = amt;
    @(negedge clk_i);
    check(req, exp_r, exp_s);
  endtask

  task automatic t_reset();
    check("R10 reset", 32'h0, 1'b0);
  endtask

  task automatic t_latency();
    run("R10 setup", 3'd3, 32'h0000_0001, 6'd0, 32'h8000_0000, 1'b0);
    @(negedge clk_i);
    op_i = 3'd3; opa_i = 32'h8000_0000;
    #1 check("R10 hold before edge", 32'h8000_0000, 1'b0);
    @(negedge clk_i);
    check("R10 after edge", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_brev();
    run("R1", 3'd0, 32'h4711_0815, 6'd0, 32'h1508_1147, 1'b0);
    run("R1", 3'd0, 32'h8000_0000, 6'd0, 32'h0000_0080, 1'b0);
    run("R1", 3'd0, 32'h0000_0080, 6'd9, 32'h8000_0000, 1'b0);
  endtask

  task automatic t_hswap();
    run("R2", 3'd1, 32'h4711_0815, 6'd0, 32'h1147_1508, 1'b0);
    run("R2", 3'd1, 32'h0000_1234, 6'd0, 32'h0000_3412, 1'b0);
  endtask

  task automatic t_shswp();
    run("R3", 3'd2, 32'h0000_1147, 6'd0, 32'h0000_4711, 1'b0);
    run("R3", 3'd2, 32'h0000_0080, 6'd0, 32'hFFFF_8000, 1'b0);
    run("R3", 3'd2, 32'h0000_8000, 6'd0, 32'h0000_0080, 1'b0);
    run("R3 upper ignored", 3'd2, 32'hABCD_0080, 6'd0, 32'hFFFF_8000, 1'b0);
    run("R3", 3'd2, 32'h0000_EDCC, 6'd0, 32'hFFFF_CCED, 1'b0);
  endtask

  task automatic t_bitrv();
    run("R4", 3'd3, 32'hAAAA_AAAA, 6'd0, 32'h5555_5555, 1'b0);
    run("R4", 3'd3, 32'h0000_0001, 6'd0, 32'h8000_0000, 1'b0);
    run("R4", 3'd3, 32'h1234_5678, 6'd0, 32'h1E6A_2C48, 1'b0);
  endtask

  task automatic t_rotr();
    run("R5", 3'd4, 32'h0000_0001, 6'd1,  32'h8000_0000, 1'b0);
    run("R5", 3'd4, 32'h8000_0000, 6'd1,  32'h4000_0000, 1'b0);
    run("R5", 3'd4, 32'h0000_0004, 6'd2,  32'h0000_0001, 1'b0);
    run("R5 by 32", 3'd4, 32'h0000_0001, 6'd32, 32'h0000_0001, 1'b0);
    run("R5 by 0", 3'd4, 32'hDEAD_BEEF, 6'd0, 32'hDEAD_BEEF, 1'b0);
    run("R5", 3'd4, 32'h4711_0815, 6'd8,  32'h1547_1108, 1'b0);
    run("R5 by 33", 3'd4, 32'h0000_0001, 6'd33, 32'h8000_0000, 1'b0);
    run("R5 by 63", 3'd4, 32'h0000_0001, 6'd63, 32'h0000_0002, 1'b0);
  endtask

  task automatic t_clz();
    run("R6 zero", 3'd5, 32'h0000_0000, 6'd0, 32'd32, 1'b0);
    run("R6", 3'd5, 32'h0000_0001, 6'd0, 32'd31, 1'b0);
    run("R6", 3'd5, 32'h4000_0000, 6'd0, 32'd1,  1'b0);
    run("R6", 3'd5, 32'h8000_0000, 6'd0, 32'd0,  1'b0);
    run("R6 R9", 3'd5, 32'hFFFF_FFFF, 6'd63, 32'd0, 1'b0);
    run("R6", 3'd5, 32'h0001_0F00, 6'd0, 32'd15, 1'b0);
  endtask

  task automatic t_ssat();
    run("R7", 3'd6, 32'h7FFF_FFFF, 6'd32, 32'h7FFF_FFFF, 1'b0);
    run("R7", 3'd6, 32'h7FFF_FFFF, 6'd16, 32'h0000_7FFF, 1'b1);
    run("R7", 3'd6, 32'h7FFF_FFFF, 6'd8,  32'h0000_007F, 1'b1);
    run("R7 w1", 3'd6, 32'h7FFF_FFFF, 6'd1, 32'h0000_0000, 1'b1);
    run("R7", 3'd6, 32'h8000_0000, 6'd32, 32'h8000_0000, 1'b0);
    run("R7", 3'd6, 32'h8000_0000, 6'd16, 32'hFFFF_8000, 1'b1);
    run("R7", 3'd6, 32'h8000_0000, 6'd8,  32'hFFFF_FF80, 1'b1);
    run("R7 w1", 3'd6, 32'h8000_0000, 6'd1, 32'hFFFF_FFFF, 1'b1);
    run("R7 w0", 3'd6, 32'h0000_0005, 6'd0, 32'h0000_0000, 1'b1);
    run("R7 w40", 3'd6, 32'h8000_0000, 6'd40, 32'h8000_0000, 1'b0);
    run("R7 R9 in range", 3'd6, 32'hFFFF_FFFB, 6'd8, 32'hFFFF_FFFB, 1'b0);
    run("R7 R9 edge", 3'd6, 32'h0000_007F, 6'd8, 32'h0000_007F, 1'b0);
    run("R7 R9 edge+1", 3'd6, 32'h0000_0080, 6'd8, 32'h0000_007F, 1'b1);
    run("R7 R9 low edge", 3'd6, 32'hFFFF_FF80, 6'd8, 32'hFFFF_FF80, 1'b0);
  endtask

  task automatic t_usat();
    run("R8", 3'd7, 32'h7FFF_FFFF, 6'd31, 32'h7FFF_FFFF, 1'b0);
    run("R8", 3'd7, 32'h7FFF_FFFF, 6'd16, 32'h0000_FFFF, 1'b1);
    run("R8", 3'd7, 32'h7FFF_FFFF, 6'd8,  32'h0000_00FF, 1'b1);
    run("R8 w0", 3'd7, 32'h7FFF_FFFF, 6'd0, 32'h0000_0000, 1'b1);
    run("R8 neg", 3'd7, 32'h8000_0000, 6'd31, 32'h0000_0000, 1'b1);
    run("R8 neg", 3'd7, 32'hFFFF_FFFF, 6'd8, 32'h0000_0000, 1'b1);
    run("R8 R9 w0 zero", 3'd7, 32'h0000_0000, 6'd0, 32'h0000_0000, 1'b0);
    run("R8 w40 neg", 3'd7, 32'hFFFF_FFFF, 6'd40, 32'h0000_0000, 1'b1);
    run("R8 w40", 3'd7, 32'h7FFF_FFFF, 6'd40, 32'h7FFF_FFFF, 1'b0);
    run("R8 R9 edge", 3'd7, 32'h0000_00FF, 6'd8, 32'h0000_00FF, 1'b0);
    run("R8 R9 edge+1", 3'd7, 32'h0000_0100, 6'd8, 32'h0000_00FF, 1'b1);
  endtask

  task automatic t_flag_other();
    for (int op = 0; op < 6; op++) begin
      @(negedge clk_i);
      op_i = 3'(op); opa_i = 32'h8000_0000; amt_i = 6'd1;
      @(negedge clk_i);
      n_vec++;
      if (sat_o !== 1'b0) begin
        n_bad++;
        $display("FAIL R9 op=%0d: sat=%b expected 0", op, sat_o);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_latency();
    t_brev();
    t_hswap();
    t_shswp();
    t_bitrv();
    t_rotr();
    t_clz();
    t_ssat();
    t_usat();
    t_flag_other();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule